// File: doc/BRIEF.md
# Planar to packed pixel serializer

This block sits in a display refresh path and turns frame-buffer words into a stream of 4-bit pixel indices. Each 32-bit word holds four byte-wide planes side by side: plane n lives in byte n. A single pixel is built by taking one bit from the same position in every plane, so one word carries eight pixels.

A word is offered with a valid/ready handshake. The block emits one pixel per clock, in left-to-right screen order, whenever its output enable is high. It raises ready again in the same cycle as the eighth pixel leaves, so words that arrive back to back produce a stream with no gaps. A 4-bit plane-enable mask is applied to every pixel as it leaves, which forces disabled planes to zero. When no word is loaded, output valid is low.

Top module: `plane_pixel_serializer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Bit j of the pixel at position i (counted from the left, 0 to 7) equals in_word bit (8*j + 7 - i), for planes j = 0..3 with all planes enabled.
- R3: The first pixel emitted from a word takes bit 7 of each plane byte. Plane 3 gives pixel bit 3 and plane 0 gives pixel bit 0.
- R4: Each accepted word yields exactly eight pixels. One pixel is consumed in each cycle where out_valid and out_en are both 1.
- R5: in_ready is 1 when no word is loaded, and also when out_en is 1 and the final pixel of the loaded word is on the output. A word is taken only in a cycle where in_valid and in_ready are both 1, and that word's first pixel appears on the next cycle with no gap.
- R6: While out_en is 0, the current pixel and its position are held, and out_valid stays 1.
- R7: Pixel bit n is 0 whenever plane_en bit n is 0, where bit n of plane_en selects plane n. The mask acts on the pixel currently presented.
- R8: out_valid is 1 exactly when a word is loaded with pixels left to emit. It drops in the cycle after the eighth pixel if no new word was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 32 | Frame-buffer word, plane n in byte n |
| in_valid | input | 1 | in_word is offered |
| in_ready | output | 1 | Block takes in_word this cycle when in_valid is high |
| out_en | input | 1 | Consume the presented pixel this cycle |
| plane_en | input | 4 | Per-plane enable mask, bit n for plane n |
| out_pix | output | 4 | Current pixel index after masking |
| out_valid | output | 1 | out_pix holds a pixel |

## Verification
If the position counter is off, the output shows it at once: bit patterns are rotated within a word, or the ready pulse comes early or late. A wrong ready pulse either leaves a one-cycle hole in out_valid or makes the block drop a word. Both show up at the ports within eight cycles of the fault. The bench streams walking-one, walking-zero and mixed words through the block and sweeps all sixteen mask values. It checks every presented pixel, along with in_ready and out_valid, against a model that counts the pixels still owed. Any mistake in plane ordering or bit position shows as a wrong nibble on the very pixel it affects.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Geometry of one frame-buffer word.
  parameter int PLANES  = 4;
  parameter int PLANE_W = 8;
  localparam int WORD_W = PLANES * PLANE_W;
  localparam int IDX_W  = $clog2(PLANE_W);

  typedef logic [PLANES-1:0] pix_t;
endpackage

// File: rtl/pps_plane_gather.sv
// Regroups a planar word into PLANE_W packed pixels, leftmost in slot 0.
module pps_plane_gather #(
  parameter int PLANES  = pps_pkg::PLANES,
  parameter int PLANE_W = pps_pkg::PLANE_W,
  localparam int WORD_W = PLANES * PLANE_W
) (
  input  logic [WORD_W-1:0]               word_i,
  output logic [PLANE_W-1:0][PLANES-1:0]  pix_o
);
  for (genvar gi = 0; gi < PLANE_W; gi++) begin : g_pix
    for (genvar gj = 0; gj < PLANES; gj++) begin : g_plane
      // screen slot gi uses bit (PLANE_W-1-gi) of plane gj
      assign pix_o[gi][gj] = word_i[gj*PLANE_W + PLANE_W - 1 - gi];
    end
  end
endmodule

// File: rtl/pps_pixel_seq.sv
// Holds one gathered word and steps through its pixels.
module pps_pixel_seq #(
  parameter int PLANES  = pps_pkg::PLANES,
  parameter int PLANE_W = pps_pkg::PLANE_W,
  localparam int IDX_W  = $clog2(PLANE_W),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PLANE_W - 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [PLANE_W-1:0][PLANES-1:0]  pix_in,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic                            out_en,
  output logic [PLANES-1:0]               cur_pix,
  output logic                            cur_valid
);
  logic [PLANE_W-1:0][PLANES-1:0] buf_q, buf_d;
  logic [IDX_W-1:0]               idx_q, idx_d;
  logic                           full_q, full_d;
  logic                           emit, at_last, take;

  // next-state logic
  always_comb begin
    emit     = full_q && out_en;
    at_last  = (idx_q == LAST_IDX);
    in_ready = !full_q || (emit && at_last);
    take     = in_valid && in_ready;

    buf_d  = buf_q;
    idx_d  = idx_q;
    full_d = full_q;
    if (take) begin
      buf_d  = pix_in;
      idx_d  = '0;
      full_d = 1'b1;
    end else if (emit) begin
      if (at_last) begin
        idx_d  = '0;
        full_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  // state registers; buffer written only on a load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (take) begin
      buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      full_q <= full_d;
    end
  end

  assign cur_pix   = buf_q[idx_q];
  assign cur_valid = full_q;
endmodule

// File: rtl/pps_plane_mask.sv
// Forces disabled planes to zero in the outgoing pixel.
module pps_plane_mask #(
  parameter int PLANES = pps_pkg::PLANES
) (
  input  logic [PLANES-1:0] pix_i,
  input  logic [PLANES-1:0] en_i,
  output logic [PLANES-1:0] pix_o
);
  for (genvar gp = 0; gp < PLANES; gp++) begin : g_bit
    assign pix_o[gp] = pix_i[gp] & en_i[gp];
  end
endmodule

// File: rtl/plane_pixel_serializer.sv
module plane_pixel_serializer #(
  parameter int PLANES  = pps_pkg::PLANES,
  parameter int PLANE_W = pps_pkg::PLANE_W,
  localparam int WORD_W = PLANES * PLANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              out_en,
  input  logic [PLANES-1:0] plane_en,
  output logic [PLANES-1:0] out_pix,
  output logic              out_valid
);
  logic [PLANE_W-1:0][PLANES-1:0] gathered;
  logic [PLANES-1:0]              raw_pix;

  pps_plane_gather #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_gather (
    .word_i (in_word),
    .pix_o  (gathered)
  );

  pps_pixel_seq #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_in    (gathered),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_en    (out_en),
    .cur_pix   (raw_pix),
    .cur_valid (out_valid)
  );

  pps_plane_mask #(.PLANES(PLANES)) u_mask (
    .pix_i (raw_pix),
    .en_i  (plane_en),
    .pix_o (out_pix)
  );
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int PLANES  = pps_pkg::PLANES,
  parameter int PLANE_W = pps_pkg::PLANE_W,
  localparam int CNT_W  = $clog2(PLANE_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_en,
  input logic [PLANES-1:0] plane_en,
  input logic [PLANES-1:0] out_pix,
  input logic              out_valid
);
  logic [CNT_W-1:0] sent_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_cnt <= '0;
    end else if (in_valid && in_ready) begin
      sent_cnt <= '0;
    end else if (out_valid && out_en) begin
      sent_cnt <= sent_cnt + 1'b1;
    end
  end

  // R4
  word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sent_cnt < CNT_W'(PLANE_W)));

  // R5
  load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_en) |=> (out_valid && (!$stable(plane_en) || $stable(out_pix))));

  // R7
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pix & ~plane_en) == '0);

  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind plane_pixel_serializer pps_checker #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_chk (.*);

// File: tb/plane_pixel_serializer_bench.sv
`timescale 1ns/1ps
module plane_pixel_serializer_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] in_word;
  logic        in_valid;
  logic        in_ready;
  logic        out_en;
  logic [3:0]  plane_en;
  logic [3:0]  out_pix;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0] q[$];   // pixels still owed, unmasked, leftmost first
  int popped;
  int gaps;

  plane_pixel_serializer u_plane_pixel_serializer (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [3:0] exp_pix(logic [31:0] w, int i);
    logic [3:0] p;
    for (int j = 0; j < 4; j++) p[j] = w[j*8 + 7 - i];
    return p;
  endfunction

  function automatic logic [31:0] gen_word(int k, int mode);
    case (mode)
      0:       return 32'h1 << (k % 32);
      1:       return ~(32'h1 << (k % 32));
      default: return (k * 32'h9E3779B9) ^ (k << 7) ^ 32'h5A0F;
    endcase
  endfunction

  // One clock: drive at the falling edge, sample 1 ns later.
  task automatic cycle(bit v, logic [31:0] w, bit en, logic [3:0] m, output bit took);
    @(negedge clk);
    in_valid = v; in_word = w; out_en = en; plane_en = m;
    #1;
    check("R8", 32'(out_valid), 32'(q.size() != 0));
    check("R5", 32'(in_ready), 32'((q.size() == 0) || (en && q.size() == 1)));
    if (out_valid && q.size() != 0) begin
      if (!en)                check("R6", 32'(out_pix), 32'(q[0] & m));
      else if (m != 4'hF)     check("R7", 32'(out_pix), 32'(q[0] & m));
      else if (q.size() == 8) check("R3", 32'(out_pix), 32'(q[0]));
      else                    check("R2", 32'(out_pix), 32'(q[0]));
    end
    if (out_valid && en && q.size() != 0) begin
      void'(q.pop_front());
      popped++;
    end
    took = v && in_ready;
    if (took) for (int i = 0; i < 8; i++) q.push_back(exp_pix(w, i));
  endtask

  // Stream nwords words; en_mode/v_mode pick stall patterns, m_mode the mask.
  task automatic stream(int nwords, int mode, int en_mode, int v_mode, int m_mode);
    int k = 0;
    int cyc = 0;
    bit took;
    popped = 0;
    gaps = 0;
    while (k < nwords || q.size() != 0) begin
      bit v  = (k < nwords) && (v_mode == 0 || (cyc % 11) < 7);
      bit en = (en_mode == 0) || ((cyc % 5) != 3);
      logic [3:0] m = (m_mode == 0) ? 4'hF : 4'(cyc);
      cycle(v, gen_word(k, mode), en, m, took);
      if (k > 0 && k < nwords && !out_valid) gaps++;
      if (took) k++;
      cyc++;
    end
    // R4: eight pixels per accepted word
    check("R4", 32'(popped), 32'(nwords * 8));
  endtask

  initial begin
    bit took;
    rst_n = 1'b0; in_valid = 0; in_word = '0; out_en = 0; plane_en = 4'hF;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", 32'(out_valid), 0);
    check("R1", 32'(in_ready), 1);
    rst_n = 1'b1;

    // R3: all planes set at bit 7 gives F first, then zeros
    cycle(1, 32'h80808080, 1, 4'hF, took);
    for (int i = 0; i < 9; i++) cycle(0, '0, 1, 4'hF, took);

    // R2 walking one and walking zero, continuous flow, R5 no bubbles
    stream(32, 0, 0, 0, 0);
    check("R5", 32'(gaps), 0);
    stream(32, 1, 0, 0, 0);
    check("R5", 32'(gaps), 0);
    // R6 output stalls and input starvation
    stream(40, 2, 1, 1, 0);
    // R7 mask sweep across all values
    stream(40, 2, 0, 0, 1);
    stream(24, 1, 1, 1, 1);

    // R8: drain then idle
    for (int i = 0; i < 3; i++) cycle(0, '0, 1, 4'hF, took);

    // R1 reset in mid-word
    cycle(1, 32'hDEADBEEF, 1, 4'hF, took);
    cycle(0, '0, 1, 4'hF, took);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    q.delete();
    check("R1", 32'(out_valid), 0);
    check("R1", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    stream(4, 2, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule